// File: doc/BRIEF.md
# Auto-Reload Programmable Interval Timer

A down-counter that advances once per time-base tick. Software loads it through a write strobe with data. Any nonzero load starts the count. When the counter steps from 1 to 0 it raises a one-cycle expiry pulse. In one-shot mode it then rests at zero. In periodic mode it restarts from a shadow copy of the most recent value written.

Every expiry sets a sticky status flag, whatever the state of the interrupt enables. Software clears the flag by strobing a write-one clear. The interrupt request is the status flag gated by a local timer enable and by an external enable. An expiry that happens while the interrupt is masked therefore stays pending until it is either unmasked or cleared.

Top module: `pit_timer`

## Requirements
- R1: With no write in the cycle, a tick while the count is greater than 1 lowers the count by one at the next clock edge. A cycle without a tick leaves the count unchanged.
- R2: A count of 0 stays at 0 when ticks arrive and raises no expiry pulse. After reset the count is 0, the status flag is 0 and the shadow value is 0.
- R3: A write strobe loads the write data into both the count and the shadow value at the next edge. A write of 0 raises no expiry pulse.
- R4: `event_o` is high, combinationally, in exactly the cycle where the count is 1, a tick is present and no write is present.
- R5: With auto-reload low, the count is 0 after an expiry and no further counting happens.
- R6: With auto-reload high, an expiry loads the count with the last value written, and counting continues from that value.
- R7: An expiry sets the status flag at the next edge, even when both interrupt enables are 0.
- R8: `irq_o` is 1 exactly while the status flag, `irq_en_i` and `ext_en_i` are all 1. A set flag that is masked stays set, so the interrupt remains pending.
- R9: A `clr_status_i` strobe clears the status flag at the next edge, which removes any pending interrupt. If an expiry happens in the same cycle, the set wins.
- R10: A write in the same cycle as a tick takes priority over the decrement. It raises no expiry pulse, even when the count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base tick enable |
| wr_i | input | 1 | Count write strobe |
| wr_data_i | input | CNT_W | Value written to count and shadow |
| auto_reload_i | input | 1 | 1 = periodic, 0 = one-shot |
| irq_en_i | input | 1 | Timer interrupt enable |
| ext_en_i | input | 1 | External interrupt enable |
| clr_status_i | input | 1 | Write-one clear of the status flag |
| count_o | output | CNT_W | Current count |
| event_o | output | 1 | Expiry pulse |
| status_o | output | 1 | Sticky expiry status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is run with a tick in every cycle and also with ticks in alternate cycles. Comparing the two separates counting per tick from counting per clock. It is then run in one-shot mode and in periodic mode, including a rewrite partway through a periodic run, to show that the reload comes from the most recent write and not from the first value loaded. Writes of zero and writes that coincide with the final tick show that an expiry comes only from a decrement. The enable combinations, a masked expiry that is unmasked later, and a clear in the same cycle as an expiry separate the status behaviour from the interrupt gating.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_LOAD,
    ACT_DEC,
    ACT_EXPIRE
  } cnt_act_e;
endpackage

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             auto_reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, shadow_q, cnt_d;
  cnt_act_e         act;

  // write beats decrement; expiry only on a 1 -> 0 step
  always_comb begin
    if (wr_i)                        act = ACT_LOAD;
    else if (tick_i && cnt_q != ZERO) act = (cnt_q == ONE) ? ACT_EXPIRE : ACT_DEC;
    else                             act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD:   cnt_d = wr_data_i;
      ACT_DEC:    cnt_d = cnt_q - ONE;
      ACT_EXPIRE: cnt_d = auto_reload_i ? shadow_q : ZERO;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= ZERO;
      shadow_q <= ZERO;
    end else begin
      cnt_q <= cnt_d;
      if (act == ACT_LOAD) shadow_q <= wr_data_i;
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = (act == ACT_EXPIRE);
endmodule

// File: rtl/pit_status.sv
module pit_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic ext_en_i,
  output logic status_o,
  output logic irq_o
);
  logic status_q;

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_q <= 1'b0;
    else if (set_i)  status_q <= 1'b1;
    else if (clr_i)  status_q <= 1'b0;
  end

  assign status_o = status_q;
  assign irq_o    = status_q & irq_en_i & ext_en_i;
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             auto_reload_i,
  input  logic             irq_en_i,
  input  logic             ext_en_i,
  input  logic             clr_status_i,
  output logic [CNT_W-1:0] count_o,
  output logic             event_o,
  output logic             status_o,
  output logic             irq_o
);
  logic expire;

  pit_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .wr_i          (wr_i),
    .wr_data_i     (wr_data_i),
    .auto_reload_i (auto_reload_i),
    .count_o       (count_o),
    .expire_o      (expire)
  );

  pit_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (expire),
    .clr_i    (clr_status_i),
    .irq_en_i (irq_en_i),
    .ext_en_i (ext_en_i),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  assign event_o = expire;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             auto_reload_i,
  input logic             irq_en_i,
  input logic             ext_en_i,
  input logic             clr_status_i,
  input logic [CNT_W-1:0] count_o,
  input logic             event_o,
  input logic             status_o,
  input logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_decrement_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_i && count_o > ONE) |=> count_o == $past(count_o) - ONE);

  p_zero_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !wr_i) |=> count_o == '0);

  p_zero_no_event_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !event_o);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> count_o == $past(wr_data_i));

  p_write_no_event_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !event_o);

  p_one_shot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !auto_reload_i) |=> count_o == '0);

  p_event_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> status_o);

  p_irq_needs_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o);

  p_masked_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_status_i) |=> status_o);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && !event_o) |=> !status_o);
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pit_timer_test.sv
module pit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0, wr_i = 1'b0, auto_reload_i = 1'b0;
  logic         irq_en_i = 1'b0, ext_en_i = 1'b0, clr_status_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] count_o;
  logic         event_o, status_o, irq_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [W-1:0] m_cnt = '0;
  logic [W-1:0] m_last = '0;
  bit           m_stat = 1'b0;

  pit_timer #(.CNT_W(W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input logic [W-1:0] d, input bit tk, input bit clr);
    bit exp_ev, exp_irq;
    wr_i = wr; wr_data_i = d; tick_i = tk; clr_status_i = clr;
    #1;
    exp_ev  = tk && !wr && (m_cnt == 1);
    exp_irq = m_stat && irq_en_i && ext_en_i;
    chk(tag, "count", count_o, m_cnt);
    chk(tag, "event", W'(event_o), W'(exp_ev));
    chk(tag, "status", W'(status_o), W'(m_stat));
    chk(tag, "irq", W'(irq_o), W'(exp_irq));
    @(posedge clk_i);
    if (wr) begin
      m_cnt = d; m_last = d;
    end else if (tk && m_cnt != 0) begin
      if (m_cnt == 1) m_cnt = auto_reload_i ? m_last : '0;
      else m_cnt = m_cnt - 1;
    end
    if (exp_ev) m_stat = 1'b1;
    else if (clr) m_stat = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2: reset state and zero hold under ticks
    for (int i = 0; i < 3; i++) step("R2", 0, '0, 1, 0);
    irq_en_i = 1; ext_en_i = 1;
    // R3 / R1 / R4 / R5: one-shot from 3
    step("R3", 1, 32'd3, 0, 0);
    for (int i = 0; i < 3; i++) step("R4", 0, '0, 1, 0);
    for (int i = 0; i < 3; i++) step("R5", 0, '0, 1, 0);
    // R1: sparse ticks
    step("R1", 1, 32'd4, 0, 0);
    for (int i = 0; i < 10; i++) step("R1", 0, '0, i[0], 0);
    // R8: enable combinations on the set flag
    ext_en_i = 0; step("R8", 0, '0, 0, 0);
    irq_en_i = 0; step("R8", 0, '0, 0, 0);
    ext_en_i = 1; step("R8", 0, '0, 0, 0);
    irq_en_i = 1; step("R8", 0, '0, 0, 0);
    // R9: clear removes pending interrupt
    step("R9", 0, '0, 0, 1);
    step("R9", 0, '0, 0, 0);
    // R3: write of zero gives no event
    step("R3", 1, '0, 1, 0);
    for (int i = 0; i < 3; i++) step("R3", 0, '0, 1, 0);
    // R6: periodic, then rewrite mid-run
    auto_reload_i = 1;
    step("R6", 1, 32'd2, 0, 0);
    for (int i = 0; i < 7; i++) step("R6", 0, '0, 1, 0);
    step("R6", 1, 32'd5, 1, 0);
    for (int i = 0; i < 12; i++) step("R6", 0, '0, 1, 0);
    auto_reload_i = 0;
    step("R9", 0, '0, 0, 1);
    // R10: write coincides with final tick
    step("R10", 1, 32'd2, 0, 0);
    step("R10", 0, '0, 1, 0);
    step("R10", 1, 32'd7, 1, 0);
    step("R10", 0, '0, 0, 0);
    // R7: masked expiry sets flag, irq pends until unmasked
    irq_en_i = 0; ext_en_i = 0;
    step("R7", 1, 32'd1, 0, 0);
    step("R7", 0, '0, 1, 0);
    step("R7", 0, '0, 0, 0);
    irq_en_i = 1; ext_en_i = 1;
    step("R8", 0, '0, 0, 0);
    // R9: set wins over simultaneous clear
    step("R9", 0, '0, 0, 1);
    step("R9", 1, 32'd1, 0, 0);
    step("R9", 0, '0, 1, 1);
    step("R9", 0, '0, 0, 0);
    step("R9", 0, '0, 0, 1);
    step("R9", 0, '0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule